// File: doc/BRIEF.md
# Periodic Down-Counter Timer

This block is a 32-bit count-down timer that software controls through four word registers on a simple register bus. Software writes a reload value into the period register, which also loads the live counter at once. It then writes the control word, which has one-shot start and stop command bits. While the counter runs it falls by one on each clock. When it expires, a sticky timeout flag is set. In continuous mode the counter reloads from the period register and keeps running. In one-shot mode it halts at zero.

An interrupt line is driven as a level from the timeout flag and an enable bit in the control word. Any write to the status register clears the flag. The live count can be read at any time through a read-only snapshot register. Each bus request is one cycle wide. Read data is registered and appears on the clock edge that accepts the request.

Top module: `down_timer`

## Requirements
- R1: After reset every register reads as zero, the counter is stopped and `irq` is low.
- R2: The register is selected by address bits [3:2] (0 status, 1 control, 2 period, 3 snapshot), and bits [1:0] are ignored. An address with any bit above bit 3 set is unmapped: a write to it has no effect and a read returns zero. Read data is registered and appears on `busRdata` after the clock edge on which the read request is accepted.
- R3: Status bit 0 is the sticky timeout flag and bit 1 reads 1 exactly while the counter runs. A write of any data to status clears the flag. If an expiry happens in the same cycle, the flag stays set.
- R4: A write to period stores the value and loads it into the counter on the same edge. This load replaces the count step of that cycle.
- R5: A write to control stores the whole word, which reads back unchanged. Bit 2 starts the counter and bit 3 stops it. When both are set the counter is left stopped. The count still steps on the edge that applies a stop.
- R6: While running, the counter falls by exactly one per clock. While stopped it holds its value. A snapshot read returns the count as it stood before the accepting edge.
- R7: Expiry is the running cycle in which the count is 1 or 0, so a period of 0 expires on the first clock after start. Expiry sets the timeout flag. With control bit 1 clear, the count goes to 0 and the counter stops.
- R8: With control bit 1 set, expiry reloads the count from the period register and the counter keeps running, so period P > 0 gives one timeout every P clocks.
- R9: `irq` is high exactly when the timeout flag and control bit 0 are both set. It follows writes to control and status on the next edge.
- R10: A write to the snapshot register has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request valid for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A continuous run with period 4 is followed by snapshot reads on every cycle. This shows the exact step-by-one sequence and the reload point, which an off-by-one expiry test would shift. Status writes are placed both on an expiry cycle and off it, which separates set-wins priority from a plain clear. One-shot runs with periods 0 and 3 show whether the counter halts at zero and when RUN drops. Writes to unmapped addresses, to aliased addresses and to snapshot, and a control word with both start and stop set, are each followed by readback. A readback shows that nothing changed.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  // word index of each register, decoded from address bits [3:2]
  localparam int unsigned IDX_STATUS   = 0;
  localparam int unsigned IDX_CONTROL  = 1;
  localparam int unsigned IDX_PERIOD   = 2;
  localparam int unsigned IDX_SNAPSHOT = 3;

  // status bit positions
  localparam int unsigned ST_TIMEOUT = 0;
  localparam int unsigned ST_RUNNING = 1;

  // control bit positions
  localparam int unsigned CT_IRQ_EN = 0;
  localparam int unsigned CT_CONT   = 1;
  localparam int unsigned CT_START  = 2;
  localparam int unsigned CT_STOP   = 3;

  // strobes from the bus-side control to the counter datapath
  typedef struct packed {
    logic loadPeriod;
    logic clearTimeout;
    logic cmdStart;
    logic cmdStop;
  } dtmr_strobe_t;

endpackage

// File: rtl/dtmr_datapath.sv
module dtmr_datapath
  import dtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtmr_strobe_t      strobe,
  input  logic              contMode,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] period,
  output logic              running,
  output logic              timeout
);

  logic tickOn;
  logic atEnd;
  logic expire;
  logic [DATA_W-1:0] countNext;
  logic runNext;

  // a period load replaces the step of this cycle
  assign tickOn = running && !strobe.loadPeriod;
  // count of 1 or 0 means the next step would reach or pass zero
  assign atEnd  = ~|count[DATA_W-1:1];
  assign expire = tickOn && atEnd;

  always_comb begin
    if (strobe.loadPeriod)  countNext = wrData;
    else if (expire)        countNext = contMode ? period : '0;
    else if (tickOn)        countNext = count - DATA_W'(1);
    else                    countNext = count;
  end

  always_comb begin
    if (strobe.cmdStart || strobe.cmdStop) runNext = strobe.cmdStart && !strobe.cmdStop;
    else if (expire && !contMode)          runNext = 1'b0;
    else                                   runNext = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      period  <= '0;
      running <= 1'b0;
      timeout <= 1'b0;
    end else begin
      count   <= countNext;
      running <= runNext;
      if (strobe.loadPeriod) period <= wrData;
      if (expire)                   timeout <= 1'b1;
      else if (strobe.clearTimeout) timeout <= 1'b0;
    end
  end

endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] period,
  input  logic              running,
  input  logic              timeout,
  output dtmr_strobe_t      strobe,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] busRdata
);

  localparam int unsigned IDX_W = 2;

  logic hiZero;
  logic [IDX_W-1:0] wordIdx;
  logic wrHit;
  logic rdHit;
  logic wrCtrl;
  logic [DATA_W-1:0] rdMux;
  logic unusedAddrLow;

  generate
    if (ADDR_W > 4) begin : g_hiDecode
      assign hiZero = ~|busAddr[ADDR_W-1:4];
    end else begin : g_noHi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign wordIdx       = busAddr[3:2];
  assign unusedAddrLow = ^busAddr[1:0];
  assign wrHit         = busValid && busWrite && hiZero;
  assign rdHit         = busValid && !busWrite;
  assign wrCtrl        = wrHit && (wordIdx == IDX_W'(IDX_CONTROL));

  assign strobe.loadPeriod   = wrHit && (wordIdx == IDX_W'(IDX_PERIOD));
  assign strobe.clearTimeout = wrHit && (wordIdx == IDX_W'(IDX_STATUS));
  assign strobe.cmdStart     = wrCtrl && busWdata[CT_START];
  assign strobe.cmdStop      = wrCtrl && busWdata[CT_STOP];

  always_comb begin
    rdMux = '0;
    if (hiZero) begin
      unique case (wordIdx)
        IDX_W'(IDX_STATUS): begin
          rdMux[ST_TIMEOUT] = timeout;
          rdMux[ST_RUNNING] = running;
        end
        IDX_W'(IDX_CONTROL):  rdMux = ctrlWord;
        IDX_W'(IDX_PERIOD):   rdMux = period;
        default:              rdMux = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      busRdata <= '0;
    end else begin
      if (wrCtrl) ctrlWord <= busWdata;
      if (rdHit)  busRdata <= rdMux;
    end
  end

endmodule

// File: rtl/down_timer.sv
module down_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  dtmr_strobe_t      strobe;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] dpCount;
  logic [DATA_W-1:0] dpPeriod;
  logic              dpRunning;
  logic              dpTimeout;

  dtmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .count    (dpCount),
    .period   (dpPeriod),
    .running  (dpRunning),
    .timeout  (dpTimeout),
    .strobe   (strobe),
    .ctrlWord (ctrlWord),
    .busRdata (busRdata)
  );

  dtmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .contMode (ctrlWord[CT_CONT]),
    .wrData   (busWdata),
    .count    (dpCount),
    .period   (dpPeriod),
    .running  (dpRunning),
    .timeout  (dpTimeout)
  );

  assign irq = dpTimeout && ctrlWord[CT_IRQ_EN];

endmodule

// File: rtl/down_timer_chk.sv
module down_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic              running,
  input logic              timeout,
  input logic              ienBit,
  input logic              contBit
);

  logic mapped, wrSt, wrCt, wrPer, atEnd;
  logic unusedLow;

  assign unusedLow = ^busAddr[1:0];
  assign mapped = (busAddr >> 4) == '0;
  assign wrSt   = busValid && busWrite && mapped && busAddr[3:2] == 2'd0;
  assign wrCt   = busValid && busWrite && mapped && busAddr[3:2] == 2'd1;
  assign wrPer  = busValid && busWrite && mapped && busAddr[3:2] == 2'd2;
  assign atEnd  = count < DATA_W'(2);

  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrPer |=> count == $past(busWdata));                                   // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    running && !atEnd && !wrPer |=> count == $past(count) - DATA_W'(1));   // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !running && !wrPer |=> count == $past(count));                         // R6
  AST_START_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wrCt && busWdata[3] |=> !running);                                     // R5
  AST_START: assert property (@(posedge clk) disable iff (!rstN)
    wrCt && busWdata[2] && !busWdata[3] |=> running);                      // R5
  AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wrSt && !(running && atEnd) |=> !timeout);                             // R3
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timeout && !wrSt |=> timeout);                                         // R3
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rstN)
    running && atEnd && !contBit && !wrCt && !wrPer
      |=> !running && timeout && count == '0);                             // R7
  AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    running && atEnd && contBit && !wrCt && !wrPer |=> running && timeout); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ienBit && timeout);                                            // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    ienBit && timeout |-> irq);                                            // R9

endmodule

bind down_timer down_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irq      (irq),
  .count    (dpCount),
  .running  (dpRunning),
  .timeout  (dpTimeout),
  .ienBit   (ctrlWord[0]),
  .contBit  (ctrlWord[1])
);

// File: tb/down_timer_bench.sv
module down_timer_bench;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int unsigned NV = 48;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  // row: {op, req tag, address, write data, expected read data}
  localparam logic [81:0] VEC [NV] = '{
    {OP_WR, 8'd4,  8'h08, 32'h4,   32'h0},   // R4 period 4
    {OP_WR, 8'd5,  8'h04, 32'h7,   32'h0},   // R5 ien|cont|start
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'h4},   // R6
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'h3},   // R6
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'h2},   // R6
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'h1},   // R6 expiry edge
    {OP_RD, 8'd8,  8'h0C, 32'h0,   32'h4},   // R8 reloaded
    {OP_RD, 8'd3,  8'h00, 32'h0,   32'h3},   // R3 run+timeout
    {OP_RD, 8'd5,  8'h04, 32'h0,   32'h7},   // R5 readback
    {OP_WR, 8'd3,  8'h00, 32'hFFFF,32'h0},   // R3 clear on expiry cycle
    {OP_RD, 8'd3,  8'h00, 32'h0,   32'h3},   // R3 set wins
    {OP_WR, 8'd3,  8'h00, 32'h0,   32'h0},   // R3 plain clear
    {OP_RD, 8'd3,  8'h00, 32'h0,   32'h2},   // R3
    {OP_RD, 8'd8,  8'h0C, 32'h0,   32'h1},   // R8 expiry again
    {OP_RD, 8'd8,  8'h00, 32'h0,   32'h3},   // R8
    {OP_WR, 8'd5,  8'h04, 32'h8,   32'h0},   // R5 stop
    {OP_RD, 8'd5,  8'h0C, 32'h0,   32'h2},   // R5 stepped on stop edge
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'h2},   // R6 holds
    {OP_RD, 8'd3,  8'h00, 32'h0,   32'h1},   // R3 sticky
    {OP_RD, 8'd2,  8'h10, 32'h0,   32'h0},   // R2 unmapped read
    {OP_WR, 8'd2,  8'h14, 32'h4,   32'h0},   // R2 unmapped write
    {OP_RD, 8'd2,  8'h00, 32'h0,   32'h1},   // R2 still stopped
    {OP_WR, 8'd10, 8'h0C, 32'h55,  32'h0},   // R10
    {OP_RD, 8'd10, 8'h0C, 32'h0,   32'h2},   // R10
    {OP_RD, 8'd2,  8'h09, 32'h0,   32'h4},   // R2 low bits ignored
    {OP_WR, 8'd5,  8'h04, 32'hC,   32'h0},   // R5 start+stop
    {OP_RD, 8'd5,  8'h00, 32'h0,   32'h1},   // R5 stopped
    {OP_WR, 8'd3,  8'h00, 32'h0,   32'h0},   // R3 clear
    {OP_WR, 8'd7,  8'h08, 32'h0,   32'h0},   // R7 period 0
    {OP_WR, 8'd7,  8'h04, 32'h4,   32'h0},   // R7 one-shot start
    {OP_RD, 8'd7,  8'h00, 32'h0,   32'h2},   // R7
    {OP_RD, 8'd7,  8'h00, 32'h0,   32'h1},   // R7 expired at once
    {OP_RD, 8'd7,  8'h0C, 32'h0,   32'h0},   // R7
    {OP_WR, 8'd3,  8'h00, 32'h0,   32'h0},   // R3
    {OP_WR, 8'd7,  8'h08, 32'h3,   32'h0},   // R7 period 3
    {OP_WR, 8'd7,  8'h04, 32'h4,   32'h0},   // R7
    {OP_RD, 8'd7,  8'h0C, 32'h0,   32'h3},   // R7
    {OP_RD, 8'd7,  8'h0C, 32'h0,   32'h2},   // R7
    {OP_RD, 8'd7,  8'h00, 32'h0,   32'h2},   // R7 expiry edge
    {OP_RD, 8'd7,  8'h00, 32'h0,   32'h1},   // R7 halted
    {OP_RD, 8'd7,  8'h0C, 32'h0,   32'h0},   // R7 at zero
    {OP_WR, 8'd8,  8'h04, 32'h6,   32'h0},   // R8 cont start
    {OP_RD, 8'd8,  8'h0C, 32'h0,   32'h0},   // R8
    {OP_WR, 8'd4,  8'h08, 32'h100, 32'h0},   // R4 load while running
    {OP_RD, 8'd4,  8'h0C, 32'h0,   32'h100}, // R4
    {OP_RD, 8'd6,  8'h0C, 32'h0,   32'hFF},  // R6
    {OP_RD, 8'd4,  8'h08, 32'h0,   32'h100}, // R4
    {OP_WR, 8'd5,  8'h04, 32'h8,   32'h0}    // R5 stop
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          irq;

  int total = 0;
  int failed = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [DW-1:0] rv;

  down_timer #(.DATA_W(DW), .ADDR_W(AW)) u_down_timer (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic chk(input int tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL R%0d: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    busValid = (op != 2'd0);
    busWrite = (op == OP_WR);
    busAddr  = a;
    busWdata = d;
    @(negedge clk);
    busValid = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] r);
    step(OP_RD, a, '0);
    r = busRdata;
  endtask

  task automatic doIdle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, {31'b0, irq}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      doRead(AW'(k * 4), rv);
      chk(1, rv, 32'h0);
    end

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][81:80], VEC[v][71:64], VEC[v][63:32]);
      if (VEC[v][81:80] == OP_RD) chk(int'(VEC[v][79:72]), busRdata, VEC[v][31:0]);
    end

    // R9 interrupt level
    step(OP_WR, 8'h00, 32'h0);
    step(OP_WR, 8'h08, 32'h2);
    step(OP_WR, 8'h04, 32'h5);
    doIdle(4);
    chk(9, {31'b0, irq}, 32'h1);
    doRead(8'h00, rv);
    chk(9, rv, 32'h1);
    step(OP_WR, 8'h04, 32'h0);
    chk(9, {31'b0, irq}, 32'h0);
    step(OP_WR, 8'h04, 32'h1);
    chk(9, {31'b0, irq}, 32'h1);
    step(OP_WR, 8'h00, 32'h0);
    chk(9, {31'b0, irq}, 32'h0);

    // R1 reset in the middle of a continuous run
    step(OP_WR, 8'h08, 32'h5);
    step(OP_WR, 8'h04, 32'h7);
    doIdle(7);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, {31'b0, irq}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      doRead(AW'(k * 4), rv);
      chk(1, rv, 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule